// File: doc/BRIEF.md
# Serial ADC conversion port sequencer

This block is the digital controller of a small 8-bit successive-approximation converter that talks over a three-wire serial port: an active-low select, a serial clock and a data-in line, plus a data-out line with its own output enable. While the select line is high the converter is shut down, and clock and data activity is ignored. Once the select line drops, the block waits for a start bit and then takes three configuration bits: single-ended or differential input, channel/polarity choice, and result bit order. It runs the sample phase, then holds the sample and resolves one result bit per falling serial clock edge. It drives a trial code to an external DAC and reads back a one-bit comparator decision.

All serial inputs are sampled by a fast system clock through a synchronizer. Serial clock edges are detected in the system clock domain, so every output is a register that updates a few system clocks after the serial edge that causes it. The result frame is a null bit of zero, then the result MSB first. An optional LSB-first repeat reuses the last bit, and after that zeros follow for as long as the select line stays low.

Top module: `adcs_seq`

## Requirements
- R1: While `cs_n` is high the block is shut down. `pwr_down` is 1, `dout_oe` is 0, `sampling` is 0, `dac_code` is 0 and `chan_sel` is 2'b00. Toggling `sclk` and `din` in this state changes none of these.
- R2: After `cs_n` falls, the first rising `sclk` edge that sees `din`=1 is the start bit. Rising edges with `din`=0 before it are ignored. Values of `din` after the configuration bits do not restart the frame.
- R3: The three rising edges after the start bit latch, in this order, SGL (1 = single-ended), ODD, and MSBF. `chan_sel` is a one-hot positive-input select: 2'b01 selects CH0 and 2'b10 selects CH1, and it is chosen by ODD (ODD=1 selects CH1). `ref_gnd` equals SGL: 1 means the negative input is ground, 0 means it is the other channel.
- R4: `sampling` is 1 from the start-bit rising edge until the falling edge after the MSBF bit. It is 0 on that falling edge, which is the 4th falling edge counted from the start bit.
- R5: `dout_oe` stays 0 until that 4th falling edge. On that edge `dout_oe` becomes 1 and `dout` presents the null bit 0.
- R6: On the 4th falling edge `dac_code` becomes 8'h80. Each of the next 8 falling edges keeps the trial bit if `cmp_in` is 1 and clears it if `cmp_in` is 0, then sets the next lower trial bit. After the 8th decision `dac_code` holds the result.
- R7: Falling edges 5 to 12 drive result bits B7 down to B0 on `dout`, one bit per edge.
- R8: If MSBF is 0, falling edges 13 to 19 drive B1 up to B7, so B0 is shared.
- R9: After the last result bit (edge 12 with MSBF=1, edge 19 with MSBF=0), `dout` is 0 on every further falling edge while `cs_n` stays low.
- R10: A rising `cs_n` at any point of a frame aborts it and returns the block to the R1 state. The next frame then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low; high means shutdown |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in (start and configuration bits) |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above `dac_code` |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |
| pwr_down | output | 1 | Shutdown indication |
| sampling | output | 1 | Sample phase active (0 = hold) |
| dac_code | output | DATA_W | Trial/result code driven to the DAC |
| chan_sel | output | 2 | One-hot positive-input channel select |
| ref_gnd | output | 1 | 1 = negative input is ground |

## Verification
The bench emulates the analog side by comparing a chosen input value against the live `dac_code`. A correct SAR therefore returns exactly that value. The values 8'hA5, 8'h3C, 8'h96 and the extremes 8'h00 and 8'hFF separate bit-order and keep/clear errors from stuck trial bits. Frames vary the number of leading zero bits, all four SGL/ODD settings, both bit orders, and idle `din` levels of 0 and 1 after configuration, so the start detection can be told apart from start re-detection. Serial activity while deselected, and a frame cut short mid-conversion, show whether shutdown and abort fully clear the state.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_CFG,
    ST_ARM,
    ST_CONV,
    ST_REV,
    ST_TAIL
  } adcs_state_e;

  localparam int IN_CS   = 0;
  localparam int IN_SCLK = 1;
  localparam int IN_DIN  = 2;
  localparam int IN_CMP  = 3;
  localparam int IN_NUM  = 4;
endpackage

// File: rtl/adcs_sync.sv
module adcs_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= {STAGES{RST_VAL[g]}};
      else     sh <= STAGES'({sh, d[g]});
    end
    assign q[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/adcs_sar.sv
module adcs_sar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         start,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code <= '0;
      mask <= '0;
    end else if (start) begin
      code <= TOP;
      mask <= TOP;
    end else if (step && (mask != '0)) begin
      code <= (code & ~mask) | (cmp ? mask : '0) | (mask >> 1);
      mask <= mask >> 1;
    end
  end

  assert_one_trial_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask));

  assert_decide_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !clear && mask != '0) |=>
      ((code & $past(mask)) == ($past(cmp) ? $past(mask) : '0)));

  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !clear && mask != '0) |=>
      ((code & ~($past(mask) | ($past(mask) >> 1))) ==
       ($past(code) & ~($past(mask) | ($past(mask) >> 1)))));
endmodule

// File: rtl/adcs_seq.sv
module adcs_seq #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              cmp_in,
  output logic              dout,
  output logic              dout_oe,
  output logic              pwr_down,
  output logic              sampling,
  output logic [DATA_W-1:0] dac_code,
  output logic [1:0]        chan_sel,
  output logic              ref_gnd
);
  import adcs_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] TOP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [IN_NUM-1:0] raw, s;
  assign raw = {cmp_in, din, sclk, cs_n};

  adcs_sync #(
    .WIDTH(IN_NUM), .STAGES(SYNC_STAGES), .RST_VAL(IN_NUM'(1))
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(s)
  );

  logic cs_s, sclk_s, din_s, cmp_s;
  assign cs_s   = s[IN_CS];
  assign sclk_s = s[IN_SCLK];
  assign din_s  = s[IN_DIN];
  assign cmp_s  = s[IN_CMP];

  logic sclk_q;
  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  logic rise, fall;
  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  adcs_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             sgl_q, msbf_q;

  logic sar_start, sar_step;
  assign sar_start = (state == ST_ARM)  && fall && !cs_s;
  assign sar_step  = (state == ST_CONV) && fall && !cs_s;

  adcs_sar #(.W(DATA_W)) u_sar (
    .clk(clk), .rst(rst), .clear(cs_s), .start(sar_start),
    .step(sar_step), .cmp(cmp_s), .code(dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      state    <= ST_OFF;
      cnt      <= '0;
      sgl_q    <= 1'b0;
      msbf_q   <= 1'b0;
      dout     <= 1'b0;
      dout_oe  <= 1'b0;
      pwr_down <= 1'b1;
      sampling <= 1'b0;
      chan_sel <= 2'b00;
      ref_gnd  <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          state    <= ST_WAIT;
          pwr_down <= 1'b0;
        end
        ST_WAIT: begin
          if (rise && din_s) begin
            state    <= ST_CFG;
            cnt      <= '0;
            sampling <= 1'b1;
          end
        end
        ST_CFG: begin
          if (rise) begin
            cnt <= cnt + 1'b1;
            case (cnt)
              CNT_W'(0): sgl_q <= din_s;
              CNT_W'(1): begin
                chan_sel <= din_s ? 2'b10 : 2'b01;
                ref_gnd  <= sgl_q;
              end
              default: begin
                msbf_q <= din_s;
                state  <= ST_ARM;
              end
            endcase
          end
        end
        ST_ARM: begin
          if (fall) begin
            sampling <= 1'b0;
            dout_oe  <= 1'b1;
            dout     <= 1'b0;
            cnt      <= '0;
            state    <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (fall) begin
            dout <= cmp_s;
            if (cnt == LAST) begin
              cnt   <= CNT_W'(1);
              state <= msbf_q ? ST_TAIL : ST_REV;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_REV: begin
          if (fall) begin
            dout <= dac_code[cnt[IDX_W-1:0]];
            if (cnt == LAST) state <= ST_TAIL;
            else             cnt   <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (fall) dout <= 1'b0;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assert_shutdown_R1: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (pwr_down && !dout_oe && !sampling && dac_code == '0));

  assert_start_seen_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sampling) |-> $past(rise && din_s));

  assert_hold_excl_R4: assert property (@(posedge clk) disable iff (rst)
    sampling |-> !dout_oe);

  assert_null_bit_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_oe) |-> (!dout && dac_code == TOP));

  assert_tail_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL && fall && !cs_s) |=> !dout);

  assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_s) |=> (state == ST_OFF && !dout_oe));
endmodule

// File: tb/adcs_seq_tb.sv
module adcs_seq_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic       cmp_in;
  logic       dout, dout_oe, pwr_down, sampling, ref_gnd;
  logic [7:0] dac_code;
  logic [1:0] chan_sel;
  logic [7:0] vin_cur = 8'h00;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  assign cmp_in = (vin_cur >= dac_code);

  adcs_seq u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .cmp_in(cmp_in), .dout(dout), .dout_oe(dout_oe), .pwr_down(pwr_down),
    .sampling(sampling), .dac_code(dac_code), .chan_sel(chan_sel),
    .ref_gnd(ref_gnd)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_off(input string tag);
    chk(8'(pwr_down), 8'd1, {tag, " pwr_down"});
    chk(8'(dout_oe), 8'd0, {tag, " dout_oe"});
    chk(8'(sampling), 8'd0, {tag, " sampling"});
    chk(dac_code, 8'h00, {tag, " dac_code"});
    chk(8'(chan_sel), 8'd0, {tag, " chan_sel"});
  endtask

  task automatic frame(input logic [7:0] vin, input int lead, input bit sgl,
                       input bit odd, input bit msbf, input int nclk,
                       input bit rest);
    vin_cur = vin;
    cs_n = 1'b0;
    wait_n(2 * HALF);
    chk(8'(pwr_down), 8'd0, "R1 awake after select");
    chk(8'(dout_oe), 8'd0, "R5 no drive before start");
    for (int i = 0; i < nclk; i++) begin
      int j = i - lead;
      int k = j + 1;
      if (j < 0)       din = 1'b0;
      else if (j == 0) din = 1'b1;
      else if (j == 1) din = sgl;
      else if (j == 2) din = odd;
      else if (j == 3) din = msbf;
      else             din = rest;
      wait_n(2);
      sclk = 1'b1;
      wait_n(HALF);
      if (j < 0) chk(8'(sampling), 8'd0, "R2 zero bits ignored");
      else if (j <= 3) chk(8'(sampling), 8'd1, "R4 sampling after start");
      sclk = 1'b0;
      wait_n(HALF - 2);
      if (k < 4) begin
        chk(8'(dout_oe), 8'd0, "R5 line released");
        if (k >= 1) chk(8'(sampling), 8'd1, "R4 still sampling");
      end else if (k == 4) begin
        chk(8'(dout_oe), 8'd1, "R5 takes line");
        chk(8'(dout), 8'd0, "R5 null bit");
        chk(8'(sampling), 8'd0, "R4 hold entered");
        chk(dac_code, 8'h80, "R6 first trial");
        chk(8'(chan_sel), odd ? 8'd2 : 8'd1, "R3 chan_sel");
        chk(8'(ref_gnd), 8'(sgl), "R3 ref_gnd");
      end else if (k <= 12) begin
        chk(8'(dout), 8'(vin[12 - k]), "R7 msb-first bit");
        if (k == 12) chk(dac_code, vin, "R6 result code");
      end else if (!msbf && k <= 19) begin
        chk(8'(dout), 8'(vin[k - 12]), "R8 lsb-first bit");
      end else begin
        chk(8'(dout), 8'd0, "R9 trailing zero");
        chk(8'(dout_oe), 8'd1, "R9 still driven");
      end
    end
    din = 1'b0;
    cs_n = 1'b1;
    wait_n(2 * HALF);
    check_off("R10 back to shutdown");
  endtask

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(6);
    check_off("R1 reset state");

    for (int t = 0; t < 6; t++) begin
      din = 1'b1;
      sclk = ~sclk;
      wait_n(HALF);
      check_off("R1 deselected activity");
    end
    sclk = 1'b0;
    wait_n(HALF);

    frame(8'hA5, 2, 1'b1, 1'b0, 1'b1, 18, 1'b0);
    frame(8'h3C, 0, 1'b0, 1'b1, 1'b0, 24, 1'b1);
    frame(8'h00, 1, 1'b1, 1'b1, 1'b0, 22, 1'b0);
    frame(8'hFF, 4, 1'b0, 1'b0, 1'b1, 16, 1'b1);
    frame(8'h5A, 0, 1'b1, 1'b0, 1'b0, 8, 1'b0);
    frame(8'h96, 0, 1'b0, 1'b0, 1'b0, 21, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule